// File: doc/BRIEF.md
# Master Serial Configuration Sequencer

This block steers the loading of a device configuration from an external serial memory while the device acts as the clock master. It makes the configuration clock by dividing the system clock. A speed pin picks the divide ratio. On each rising edge of that clock it takes one bit from the serial data input and passes it on, with a one-cycle strobe, to the frame logic downstream.

After reset the sequencer runs an initialization phase of a fixed number of cycles. During this phase it clears the configuration, drives the open-drain init line low and keeps user I/O tristated. At the end of the phase it samples the mode pins and the speed pin. A low level on the program input sends the sequencer back to initialization from any state, and the pins are sampled again when it finishes. The sequencer keeps clocking until the number of bits it has received equals the stream-length input. It then stops the clock, releases the open-drain done line and enables user I/O. An error report from the frame checker parks the sequencer in a fault state, with init held low, until the program or reset input is asserted.

Top module: `cfg_master_seq`

## Requirements
- R1: While `rst_n` is low and for CLEAR_CYCLES (default 4) clock cycles after its release, `cfg_clear` and `init_pull_low` are high, `done_pull_low` is high and `cclk` is low.
- R2: At the last initialization cycle `mode_sel` is sampled. Code 3'b000 selects master serial loading. Any other code leaves the block passive: `cclk_oe` stays low, no bits are captured and `done_pull_low` stays high.
- R3: While loading, `cclk` toggles every FAST_HALF (default 2) cycles if `speed_sel` was sampled low, and every FAST_HALF*8 cycles if it was sampled high. A rising `cclk` therefore recurs every 4 or every 32 cycles.
- R4: Each rising `cclk` is accompanied, in the same cycle, by a one-cycle high on `bit_valid`. `bit_data` then holds the `din` value present at that edge.
- R5: One cycle after the count of captured bits equals `stream_len`, `done_pull_low` drops and stays low, and `cclk` is held low. A `stream_len` of zero completes with no bit captured.
- R6: `io_hiz` is high in every state except done, and low once `done_pull_low` has dropped.
- R7: `prgm_n` low in any state returns the block to initialization on the next cycle (`cfg_clear` high) and clears the bit count. Loading restarts from zero after the phase ends.
- R8: `err` high while loading moves the block to a fault state on the next cycle: `init_pull_low` high, `done_pull_low` high, `cclk` low, `cclk_oe` low. The block stays there until `prgm_n` or `rst_n` is asserted.
- R9: Changes on `mode_sel` and `speed_sel` after initialization do not affect the current load. The `cclk` period and the bit count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| mode_sel | input | 3 | Configuration method pins |
| speed_sel | input | 1 | Clock speed pin, high selects the slow rate |
| din | input | 1 | Serial configuration data from the memory |
| prgm_n | input | 1 | Active-low reconfigure request |
| err | input | 1 | Error report from the frame checker |
| stream_len | input | 24 | Total number of bits to receive |
| cclk | output | 1 | Configuration clock to the memory |
| cclk_oe | output | 1 | Drive enable for the configuration clock pin |
| bit_data | output | 1 | Last captured data bit |
| bit_valid | output | 1 | One-cycle strobe for a newly captured bit |
| done_pull_low | output | 1 | Pulls the open-drain done line low when high |
| init_pull_low | output | 1 | Pulls the open-drain init line low when high |
| cfg_clear | output | 1 | Clears the configuration store |
| io_hiz | output | 1 | Tristates user I/O |

## Verification
The bench targets an off-by-one in the length compare. A design with that fault would release done one bit early or late, or would never finish for a zero-length stream. It also starts a reprogram partway through a load and fires an error mid-stream. A design that kept its old bit count would then finish too early, and one that ignored the error would go on clocking. The bench flips the speed and mode pins during a load, so a design that reads them live would change its clock period in the middle of the stream. It measures the spacing of captured bits at both rates, which exposes a wrong divide ratio.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

   typedef enum logic [2:0] {
      SEQ_INIT    = 3'd0,
      SEQ_LOAD    = 3'd1,
      SEQ_DONE    = 3'd2,
      SEQ_FAULT   = 3'd3,
      SEQ_PASSIVE = 3'd4
   } seq_state_e;

   localparam logic [2:0] MODE_MASTER_SERIAL = 3'b000;

endpackage

// File: rtl/cfg_cclk_gen.sv
module cfg_cclk_gen #(
   parameter int FAST_HALF  = 2,
   parameter int SLOW_RATIO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic slow,
   output logic cclk,
   output logic rise
);
   localparam int SLOW_HALF = FAST_HALF * SLOW_RATIO;
   localparam int CW        = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
   localparam logic [CW-1:0] FAST_LAST = CW'(FAST_HALF - 1);
   localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_HALF - 1);

   generate
      if (FAST_HALF < 1) begin : g_bad_fast
         $error("cfg_cclk_gen: FAST_HALF must be at least 1");
      end
      if (SLOW_RATIO < 2) begin : g_bad_ratio
         $error("cfg_cclk_gen: SLOW_RATIO must be at least 2");
      end
   endgenerate

   logic [CW-1:0] div_q;
   logic [CW-1:0] last;
   logic          term;

   always_comb begin
      last = slow ? SLOW_LAST : FAST_LAST;
      term = run && (div_q == last);
      rise = term && !cclk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cclk  <= 1'b0;
      end else if (!run) begin
         div_q <= '0;
         cclk  <= 1'b0;
      end else if (term) begin
         div_q <= '0;
         cclk  <= ~cclk;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   // R3: the clock rests low whenever the sequencer is not loading
   a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !cclk);

   // R3: a rising clock edge only follows a cycle in which loading ran
   a_r3_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cclk) |-> $past(run));

endmodule

// File: rtl/cfg_bit_capture.sv
module cfg_bit_capture (
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   input  logic din,
   output logic bit_data,
   output logic bit_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_valid <= 1'b0;
         bit_data  <= 1'b0;
      end else begin
         bit_valid <= rise;
         if (rise) bit_data <= din;
      end
   end

   // R4: the captured value is held between strobes
   a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rise) |-> $stable(bit_data));

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
   import cfg_seq_pkg::*;
#(
   parameter int LEN_W        = 24,
   parameter int CLEAR_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prgm_n,
   input  logic             err,
   input  logic [2:0]       mode_sel,
   input  logic             speed_sel,
   input  logic [LEN_W-1:0] stream_len,
   input  logic             rise,
   output seq_state_e       state,
   output logic             run,
   output logic             slow_q
);
   localparam int ICW = (CLEAR_CYCLES > 1) ? $clog2(CLEAR_CYCLES) : 1;
   localparam logic [ICW-1:0] INIT_LAST = ICW'(CLEAR_CYCLES - 1);

   generate
      if (CLEAR_CYCLES < 1) begin : g_bad_clear
         $error("cfg_seq_fsm: CLEAR_CYCLES must be at least 1");
      end
   endgenerate

   logic [ICW-1:0]   init_cnt;
   logic [LEN_W-1:0] bit_cnt;
   logic             reached;

   always_comb begin
      reached = (bit_cnt == stream_len);
      run     = (state == SEQ_LOAD) && !reached;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SEQ_INIT;
         init_cnt <= '0;
         bit_cnt  <= '0;
         slow_q   <= 1'b0;
      end else if (!prgm_n) begin
         state    <= SEQ_INIT;
         init_cnt <= '0;
         bit_cnt  <= '0;
      end else begin
         case (state)
            SEQ_INIT: begin
               bit_cnt <= '0;
               if (init_cnt == INIT_LAST) begin
                  init_cnt <= '0;
                  slow_q   <= speed_sel;
                  state    <= (mode_sel == MODE_MASTER_SERIAL) ? SEQ_LOAD : SEQ_PASSIVE;
               end else begin
                  init_cnt <= init_cnt + 1'b1;
               end
            end
            SEQ_LOAD: begin
               if (err)          state   <= SEQ_FAULT;
               else if (reached) state   <= SEQ_DONE;
               else if (rise)    bit_cnt <= bit_cnt + 1'b1;
            end
            SEQ_DONE:    state <= SEQ_DONE;
            SEQ_FAULT:   state <= SEQ_FAULT;
            SEQ_PASSIVE: state <= SEQ_PASSIVE;
            default:     state <= SEQ_INIT;
         endcase
      end
   end

   // R7: a program request restarts initialization from any state
   a_r7_prgm_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      !prgm_n |=> state == SEQ_INIT);

   // R8: an error during loading parks the sequencer in the fault state
   a_r8_err_enters: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_LOAD && err && prgm_n) |=> state == SEQ_FAULT);

   // R8: only a program request leaves the fault state
   a_r8_fault_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_FAULT && prgm_n) |=> state == SEQ_FAULT);

   // R2: loading is only entered for the master serial mode code
   a_r2_master_only: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_LOAD && $past(state) == SEQ_INIT) |-> $past(mode_sel) == MODE_MASTER_SERIAL);

   // R5: done is never reached while bits are still owed
   a_r5_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_LOAD && !reached) |=> state != SEQ_DONE);

endmodule

// File: rtl/cfg_master_seq.sv
module cfg_master_seq
   import cfg_seq_pkg::*;
#(
   parameter int LEN_W        = 24,
   parameter int FAST_HALF    = 2,
   parameter int SLOW_RATIO   = 8,
   parameter int CLEAR_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode_sel,
   input  logic             speed_sel,
   input  logic             din,
   input  logic             prgm_n,
   input  logic             err,
   input  logic [LEN_W-1:0] stream_len,
   output logic             cclk,
   output logic             cclk_oe,
   output logic             bit_data,
   output logic             bit_valid,
   output logic             done_pull_low,
   output logic             init_pull_low,
   output logic             cfg_clear,
   output logic             io_hiz
);
   generate
      if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
         $error("cfg_master_seq: LEN_W must lie in 1..32");
      end
   endgenerate

   seq_state_e state;
   logic       run;
   logic       slow_q;
   logic       rise;

   cfg_seq_fsm #(
      .LEN_W        (LEN_W),
      .CLEAR_CYCLES (CLEAR_CYCLES)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .prgm_n     (prgm_n),
      .err        (err),
      .mode_sel   (mode_sel),
      .speed_sel  (speed_sel),
      .stream_len (stream_len),
      .rise       (rise),
      .state      (state),
      .run        (run),
      .slow_q     (slow_q)
   );

   cfg_cclk_gen #(
      .FAST_HALF  (FAST_HALF),
      .SLOW_RATIO (SLOW_RATIO)
   ) u_clk (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .slow  (slow_q),
      .cclk  (cclk),
      .rise  (rise)
   );

   cfg_bit_capture u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (rise),
      .din       (din),
      .bit_data  (bit_data),
      .bit_valid (bit_valid)
   );

   always_comb begin
      cclk_oe       = (state == SEQ_LOAD);
      done_pull_low = (state != SEQ_DONE);
      io_hiz        = (state != SEQ_DONE);
      init_pull_low = (state == SEQ_INIT) || (state == SEQ_FAULT);
      cfg_clear     = (state == SEQ_INIT);
   end

   // R4: a bit strobe only appears with a rising configuration clock
   a_r4_valid_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> $rose(cclk));

   // R5: once done has been released the clock stays low
   a_r5_clock_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_pull_low && $past(!done_pull_low)) |-> !cclk);

   // R6: user I/O is never enabled while init is being pulled low
   a_r6_hiz_during_init: assert property (@(posedge clk) disable iff (!rst_n)
      init_pull_low |-> io_hiz);

endmodule

// File: tb/tb_cfg_master_seq.sv
module tb_cfg_master_seq;
   localparam int LEN_W = 24;
   localparam int FH    = 2;
   localparam int RATIO = 8;
   localparam int CC    = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       mode_sel = 3'b000;
   logic             speed_sel = 1'b0;
   logic             din = 1'b0;
   logic             prgm_n = 1'b1;
   logic             err = 1'b0;
   logic [LEN_W-1:0] stream_len = '0;
   logic cclk, cclk_oe, bit_data, bit_valid, done_pull_low, init_pull_low, cfg_clear, io_hiz;

   cfg_master_seq #(.LEN_W(LEN_W), .FAST_HALF(FH), .SLOW_RATIO(RATIO), .CLEAR_CYCLES(CC)) dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .speed_sel(speed_sel), .din(din),
      .prgm_n(prgm_n), .err(err), .stream_len(stream_len), .cclk(cclk), .cclk_oe(cclk_oe),
      .bit_data(bit_data), .bit_valid(bit_valid), .done_pull_low(done_pull_low),
      .init_pull_low(init_pull_low), .cfg_clear(cfg_clear), .io_hiz(io_hiz));

   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int stamps[$];

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // behavioural reference: 0 init, 1 load, 2 done, 3 fault, 4 passive
   int m_st, m_icnt, m_bcnt, m_div, m_half;
   bit m_cclk, m_bv, m_bd, m_slow, m_rise, m_run;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_icnt = 0; m_bcnt = 0; m_div = 0;
         m_cclk = 0; m_bv = 0; m_bd = 0; m_slow = 0;
      end else begin
         cyc++;
         m_half = m_slow ? FH * RATIO : FH;
         m_run  = (m_st == 1) && (m_bcnt != int'(stream_len));
         m_rise = 0;
         if (!m_run) begin
            m_div = 0; m_cclk = 0;
         end else if (m_div == m_half - 1) begin
            m_div = 0; m_rise = !m_cclk; m_cclk = !m_cclk;
         end else m_div++;
         m_bv = m_rise;
         if (m_rise) m_bd = din;
         if (!prgm_n) begin
            m_st = 0; m_icnt = 0; m_bcnt = 0;
         end else if (m_st == 0) begin
            m_bcnt = 0;
            if (m_icnt == CC - 1) begin
               m_icnt = 0; m_slow = speed_sel;
               m_st = (mode_sel == 3'b000) ? 1 : 4;
            end else m_icnt++;
         end else if (m_st == 1) begin
            if (err) m_st = 3;
            else if (m_bcnt == int'(stream_len)) m_st = 2;
            else if (m_rise) m_bcnt++;
         end
      end
   end

   // cycle-by-cycle comparison, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cclk == m_cclk, "R3", "cclk", cclk, m_cclk);
         chk(cclk_oe == (m_st == 1), "R2", "cclk_oe", cclk_oe, m_st == 1);
         chk(bit_valid == m_bv, "R4", "bit_valid", bit_valid, m_bv);
         chk(bit_data == m_bd, "R4", "bit_data", bit_data, m_bd);
         chk(done_pull_low == (m_st != 2), "R5", "done_pull_low", done_pull_low, m_st != 2);
         chk(io_hiz == (m_st != 2), "R6", "io_hiz", io_hiz, m_st != 2);
         chk(init_pull_low == (m_st == 0 || m_st == 3), "R8", "init_pull_low", init_pull_low, m_st == 0 || m_st == 3);
         chk(cfg_clear == (m_st == 0), "R1", "cfg_clear", cfg_clear, m_st == 0);
         if (bit_valid) stamps.push_back(cyc);
      end
      din <= 1'($urandom);
   end

   task automatic restart(input logic [2:0] m, input logic s, input int len);
      @(negedge clk);
      prgm_n = 1'b0; mode_sel = m; speed_sel = s; stream_len = LEN_W'(len);
      @(negedge clk);
      chk(cfg_clear == 1'b1, "R7", "cfg_clear after prgm", cfg_clear, 1);
      @(negedge clk);
      prgm_n = 1'b1;
   endtask

   task automatic wait_done(input int maxc, output int took);
      took = 0;
      while (done_pull_low && took < maxc) begin
         @(negedge clk);
         took++;
      end
   endtask

   task automatic check_spacing(input int b, input int half, input string req);
      if (stamps.size() >= b + 2)
         chk(stamps[b+1] - stamps[b] == 2 * half, req, "rise spacing", stamps[b+1] - stamps[b], 2 * half);
      else
         chk(1'b0, req, "too few bits for spacing", stamps.size() - b, 2);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired: actual 150000 expected below 150000");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      int took;
      int b;
      stream_len = LEN_W'(10);
      repeat (3) @(negedge clk);
      // R1: state held during reset
      chk(cfg_clear && init_pull_low, "R1", "clear during reset", cfg_clear, 1);
      chk(done_pull_low == 1'b1, "R1", "done during reset", done_pull_low, 1);
      chk(cclk == 1'b0, "R1", "cclk during reset", cclk, 0);
      b = stamps.size();
      rst_n = 1'b1;
      repeat (CC) @(negedge clk);
      chk(cfg_clear == 1'b0, "R1", "init phase length", cfg_clear, 0);

      // R5 R3 R4: fast load of 10 bits after power-up
      wait_done(500, took);
      chk(done_pull_low == 1'b0, "R5", "done after fast load", done_pull_low, 0);
      chk(stamps.size() - b == 10, "R5", "bits before done", stamps.size() - b, 10);
      check_spacing(b, FH, "R3");
      chk(io_hiz == 1'b0, "R6", "io enabled after done", io_hiz, 0);

      // R3: slow rate
      restart(3'b000, 1'b1, 5);
      b = stamps.size();
      wait_done(1000, took);
      chk(stamps.size() - b == 5, "R5", "slow bit count", stamps.size() - b, 5);
      check_spacing(b, FH * RATIO, "R3");

      // R2: non-master mode stays passive
      restart(3'b011, 1'b0, 6);
      b = stamps.size();
      repeat (60) @(negedge clk);
      chk(done_pull_low == 1'b1, "R2", "passive keeps done low", done_pull_low, 1);
      chk(cclk_oe == 1'b0, "R2", "passive cclk_oe", cclk_oe, 0);
      chk(stamps.size() == b, "R2", "passive captures", stamps.size() - b, 0);

      // R5: zero length completes without bits
      restart(3'b000, 1'b0, 0);
      b = stamps.size();
      wait_done(CC + 3, took);
      chk(done_pull_low == 1'b0, "R5", "zero length done", done_pull_low, 0);
      chk(stamps.size() == b, "R5", "zero length bits", stamps.size() - b, 0);

      // R8: error mid-stream
      restart(3'b000, 1'b0, 30);
      repeat (20) @(negedge clk);
      err = 1'b1;
      @(negedge clk);
      err = 1'b0;
      repeat (40) @(negedge clk);
      chk(init_pull_low == 1'b1, "R8", "fault holds init", init_pull_low, 1);
      chk(done_pull_low == 1'b1, "R8", "fault keeps done low", done_pull_low, 1);
      chk(cclk == 1'b0 && cclk_oe == 1'b0, "R8", "fault stops clock", cclk, 0);

      // R7: reprogram partway through a load restarts the count
      restart(3'b000, 1'b0, 16);
      repeat (25) @(negedge clk);
      restart(3'b000, 1'b0, 8);
      b = stamps.size();
      wait_done(500, took);
      chk(stamps.size() - b == 8, "R7", "bits after reprogram", stamps.size() - b, 8);

      // R9: pin changes during a load are ignored
      restart(3'b000, 1'b0, 12);
      b = stamps.size();
      repeat (CC + 8) @(negedge clk);
      speed_sel = 1'b1; mode_sel = 3'b101;
      wait_done(500, took);
      chk(done_pull_low == 1'b0, "R9", "load finished despite pins", done_pull_low, 0);
      chk(stamps.size() - b == 12, "R9", "bit count unchanged", stamps.size() - b, 12);
      if (stamps.size() >= b + 12)
         chk(stamps[b+11] - stamps[b+10] == 2 * FH, "R9", "rate unchanged", stamps[b+11] - stamps[b+10], 2 * FH);

      repeat (5) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule